// File: doc/BRIEF.md
# Single to Half Precision Narrowing Converter

This block turns a 32-bit single-precision floating-point word into a 16-bit half-precision word in a single registered stage. Each input word comes with a valid strobe and a mode bit. When the mode bit is low the result uses the standard half-precision encoding. That encoding has signed zeros, subnormals, normals, infinities and quiet NaNs. When the mode bit is high the result uses the alternative encoding, where the top exponent code holds ordinary normal numbers and no infinity or NaN exists.

Every finite input is rounded to the nearest half-precision value. An exact half-way case goes to the candidate whose last fraction bit is zero. A carry out of the fraction moves the result into the next binade. Results smaller than the smallest normal are shifted into the subnormal field, and the bits shifted out take part in the rounding. Overflow becomes a signed infinity in standard mode and a signed largest-magnitude value in alternative mode. The result and its valid flag appear on the clock edge after the input is presented.

Top module: `f32_to_f16_cvt`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. Reset clears `out_valid` and `out_word`. `out_word` keeps its value when `in_valid` is low.
- R2: The output is laid out as sign at bit 15, a 5-bit exponent biased by 15 at bits 14:10 and a 10-bit fraction at bits 9:0. Normal results are rounded to nearest with ties to even, and a fraction carry increments the exponent. For example, 1/3 (0x3EAAAAAB) gives 0x3555 and 1.0 gives 0x3C00.
- R3: In standard mode the largest finite result is 65504 (0x7BFF). A finite magnitude that rounds above it gives sign plus 0x7C00. For example, 65520 gives 0x7C00.
- R4: Magnitudes below 2^-14 give exponent 0 with the fraction rounded to nearest-even in units of 2^-24. Exactly 2^-25 gives zero, anything above 2^-25 and up to 2^-24 gives 0x0001, and anything below 2^-25 gives signed zero.
- R5: The output sign always equals the input sign. An input zero or an input subnormal gives a signed zero in both modes.
- R6: In standard mode an input infinity gives a signed infinity, sign plus 0x7C00.
- R7: In standard mode an input NaN gives sign, exponent 31, fraction bit 9 set to 1, and fraction bits 8:0 taken from input fraction bits 21:13.
- R8: In alternative mode exponent 31 is an ordinary normal exponent, so 131008 gives 0x7FFF and 65536 gives 0x7C00. An input infinity, or a finite magnitude that rounds above 131008, gives sign plus 0x7FFF.
- R9: In alternative mode an input NaN gives a signed zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word strobe |
| in_alt | input | 1 | 0 selects the standard encoding, 1 selects the alternative encoding |
| in_word | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | 16 | Half-precision result |

## Verification
The checker watches every cycle for the valid latency, the holding of the result between strobes and the preservation of the sign. It also checks the fixed outcomes that depend only on the input exponent: flush to zero for tiny inputs, infinity in standard mode for huge inputs, saturation in alternative mode for huge inputs and infinities, and the quiet form of NaNs. The exact rounded values cannot be checked that way. Ties to even, carries into the next binade, rounding inside the subnormal range and the exact limits at 65504, 65520 and 131008 are shown only by the bench. The bench sweeps every input exponent against fraction patterns near each rounding boundary, in both modes, and compares each result with an arithmetic model.

// File: rtl/f16cvt_pkg.sv
package f16cvt_pkg;

   typedef enum logic [1:0] {
      CLS_ZERO   = 2'd0,
      CLS_FINITE = 2'd1,
      CLS_INF    = 2'd2,
      CLS_NAN    = 2'd3
   } op_cls_e;

endpackage

// File: rtl/f16cvt_unpack.sv
module f16cvt_unpack
   import f16cvt_pkg::*;
#(
   parameter int IN_EXP   = 8,
   parameter int IN_FRAC  = 23,
   parameter int OUT_EXP  = 5,
   parameter int OUT_FRAC = 10,
   parameter int SHW      = 5,
   localparam int IN_W    = 1 + IN_EXP + IN_FRAC,
   localparam int EW      = IN_EXP + 2
) (
   input  logic [IN_W-1:0]       word_i,
   output logic                  sign_o,
   output op_cls_e               cls_o,
   output logic [IN_FRAC:0]      sig_o,
   output logic signed [EW-1:0]  texp_o,
   output logic [SHW-1:0]        shamt_o,
   output logic                  sub_o,
   output logic                  big_o,
   output logic [OUT_FRAC-2:0]   nan_pay_o
);

   localparam int IN_BIAS  = (1 << (IN_EXP - 1)) - 1;
   localparam int OUT_BIAS = (1 << (OUT_EXP - 1)) - 1;
   localparam int DROP     = IN_FRAC - OUT_FRAC;
   localparam int SH_CAP   = IN_FRAC + 2;
   localparam int OUT_EMAX = (1 << OUT_EXP) - 1;

   logic [IN_EXP-1:0]  exp_f;
   logic [IN_FRAC-1:0] frac_f;

   assign sign_o    = word_i[IN_W-1];
   assign exp_f     = word_i[IN_W-2 -: IN_EXP];
   assign frac_f    = word_i[IN_FRAC-1:0];
   assign sig_o     = {1'b1, frac_f};
   assign nan_pay_o = frac_f[IN_FRAC-2 -: OUT_FRAC-1];

   always_comb begin
      if (exp_f == '1)
         cls_o = (frac_f != '0) ? CLS_NAN : CLS_INF;
      else if (exp_f == '0)
         cls_o = CLS_ZERO;
      else
         cls_o = CLS_FINITE;
   end

   always_comb begin
      int t;
      int r;
      t      = int'(exp_f) - IN_BIAS + OUT_BIAS;
      texp_o = EW'(t);
      big_o  = (t > OUT_EMAX);
      sub_o  = (t < 1);
      if (t >= 1) begin
         r = DROP;
      end else begin
         r = DROP + 1 - t;
         if (r > SH_CAP)
            r = SH_CAP;
      end
      shamt_o = SHW'(r);
   end

endmodule

// File: rtl/f16cvt_rshift.sv
module f16cvt_rshift #(
   parameter int W   = 24,
   parameter int SHW = 5
) (
   input  logic [W-1:0]   data_i,
   input  logic [SHW-1:0] sh_i,
   output logic [W-1:0]   kept_o,
   output logic           guard_o,
   output logic           sticky_o
);

   localparam int VW = W + 1;

   logic [SHW:0][VW-1:0] v;
   logic [SHW:0]         st;

   assign v[0]  = {data_i, 1'b0};
   assign st[0] = 1'b0;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int N = 1 << k;
      if (N >= VW) begin : g_flush
         assign v[k+1]  = sh_i[k] ? '0 : v[k];
         assign st[k+1] = st[k] | (sh_i[k] & (|v[k]));
      end else begin : g_step
         assign v[k+1]  = sh_i[k] ? (v[k] >> N) : v[k];
         assign st[k+1] = st[k] | (sh_i[k] & (|v[k][N-1:0]));
      end
   end

   assign kept_o   = v[SHW][VW-1:1];
   assign guard_o  = v[SHW][0];
   assign sticky_o = st[SHW];

endmodule

// File: rtl/f16cvt_round.sv
module f16cvt_round #(
   parameter int OUT_EXP  = 5,
   parameter int OUT_FRAC = 10,
   parameter int KW       = 24,
   parameter int EW       = 10,
   localparam int MW      = OUT_EXP + OUT_FRAC + 1
) (
   input  logic [KW-1:0]        kept_i,
   input  logic                 guard_i,
   input  logic                 sticky_i,
   input  logic                 sub_i,
   input  logic signed [EW-1:0] texp_i,
   output logic [MW-1:0]        mag_o
);

   logic [OUT_EXP:0] te_lo;
   logic [MW-1:0]    base;
   logic             rup;

   assign te_lo = texp_i[OUT_EXP:0];
   assign rup   = guard_i & (sticky_i | kept_i[0]);
   assign base  = sub_i ? '0 : {te_lo - (OUT_EXP+1)'(1), {OUT_FRAC{1'b0}}};
   assign mag_o = base + MW'(kept_i[OUT_FRAC:0]) + MW'(rup);

endmodule

// File: rtl/f16cvt_pack.sv
module f16cvt_pack
   import f16cvt_pkg::*;
#(
   parameter int OUT_EXP  = 5,
   parameter int OUT_FRAC = 10,
   localparam int MW      = OUT_EXP + OUT_FRAC + 1,
   localparam int OW      = 1 + OUT_EXP + OUT_FRAC
) (
   input  logic                sign_i,
   input  op_cls_e             cls_i,
   input  logic                alt_i,
   input  logic                big_i,
   input  logic [MW-1:0]       mag_i,
   input  logic [OUT_FRAC-2:0] nan_pay_i,
   output logic [OW-1:0]       word_o
);

   localparam int OUT_EMAX = (1 << OUT_EXP) - 1;

   logic [OW-2:0] inf_code;
   logic [OW-2:0] sat_code;
   logic [OW-2:0] qnan_code;
   logic          ovf_std;
   logic          ovf_alt;

   assign inf_code  = {{OUT_EXP{1'b1}}, {OUT_FRAC{1'b0}}};
   assign sat_code  = '1;
   assign qnan_code = {{OUT_EXP{1'b1}}, 1'b1, nan_pay_i};
   assign ovf_std   = big_i | (int'(mag_i[MW-1:OUT_FRAC]) >= OUT_EMAX);
   assign ovf_alt   = big_i | mag_i[MW-1];

   always_comb begin
      unique case (cls_i)
         CLS_ZERO:   word_o = {sign_i, {(OW-1){1'b0}}};
         CLS_NAN:    word_o = alt_i ? {sign_i, {(OW-1){1'b0}}} : {sign_i, qnan_code};
         CLS_INF:    word_o = alt_i ? {sign_i, sat_code} : {sign_i, inf_code};
         default: begin
            if (alt_i)
               word_o = ovf_alt ? {sign_i, sat_code} : {sign_i, mag_i[OW-2:0]};
            else
               word_o = ovf_std ? {sign_i, inf_code} : {sign_i, mag_i[OW-2:0]};
         end
      endcase
   end

endmodule

// File: rtl/f32_to_f16_cvt.sv
module f32_to_f16_cvt
   import f16cvt_pkg::*;
#(
   parameter int IN_EXP   = 8,
   parameter int IN_FRAC  = 23,
   parameter int OUT_EXP  = 5,
   parameter int OUT_FRAC = 10,
   localparam int IN_W    = 1 + IN_EXP + IN_FRAC,
   localparam int OUT_W   = 1 + OUT_EXP + OUT_FRAC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_alt,
   input  logic [IN_W-1:0]  in_word,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_word
);

   localparam int SH_CAP = IN_FRAC + 2;
   localparam int SHW    = $clog2(SH_CAP + 1);
   localparam int EW     = IN_EXP + 2;
   localparam int KW     = IN_FRAC + 1;
   localparam int MW     = OUT_EXP + OUT_FRAC + 1;

   if (IN_EXP <= OUT_EXP) begin : g_bad_exp
      $error("input exponent must be wider than output exponent");
   end
   if (IN_FRAC <= OUT_FRAC) begin : g_bad_frac
      $error("input fraction must be wider than output fraction");
   end
   if (OUT_FRAC < 2) begin : g_bad_pay
      $error("output fraction needs at least two bits");
   end

   logic                 u_sign;
   op_cls_e              u_cls;
   logic [KW-1:0]        u_sig;
   logic signed [EW-1:0] u_texp;
   logic [SHW-1:0]       u_sh;
   logic                 u_sub;
   logic                 u_big;
   logic [OUT_FRAC-2:0]  u_pay;
   logic [KW-1:0]        s_kept;
   logic                 s_guard;
   logic                 s_sticky;
   logic [MW-1:0]        r_mag;
   logic [OUT_W-1:0]     nxt_word;

   f16cvt_unpack #(
      .IN_EXP(IN_EXP), .IN_FRAC(IN_FRAC),
      .OUT_EXP(OUT_EXP), .OUT_FRAC(OUT_FRAC), .SHW(SHW)
   ) u_unpack (
      .word_i(in_word), .sign_o(u_sign), .cls_o(u_cls), .sig_o(u_sig),
      .texp_o(u_texp), .shamt_o(u_sh), .sub_o(u_sub), .big_o(u_big),
      .nan_pay_o(u_pay)
   );

   f16cvt_rshift #(.W(KW), .SHW(SHW)) u_rshift (
      .data_i(u_sig), .sh_i(u_sh),
      .kept_o(s_kept), .guard_o(s_guard), .sticky_o(s_sticky)
   );

   f16cvt_round #(
      .OUT_EXP(OUT_EXP), .OUT_FRAC(OUT_FRAC), .KW(KW), .EW(EW)
   ) u_round (
      .kept_i(s_kept), .guard_i(s_guard), .sticky_i(s_sticky),
      .sub_i(u_sub), .texp_i(u_texp), .mag_o(r_mag)
   );

   f16cvt_pack #(.OUT_EXP(OUT_EXP), .OUT_FRAC(OUT_FRAC)) u_pack (
      .sign_i(u_sign), .cls_i(u_cls), .alt_i(in_alt), .big_i(u_big),
      .mag_i(r_mag), .nan_pay_i(u_pay), .word_o(nxt_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_word <= nxt_word;
      end
   end

endmodule

// File: rtl/f16cvt_chk.sv
module f16cvt_chk #(
   parameter int IN_EXP   = 8,
   parameter int IN_FRAC  = 23,
   parameter int OUT_EXP  = 5,
   parameter int OUT_FRAC = 10,
   localparam int IN_W    = 1 + IN_EXP + IN_FRAC,
   localparam int OUT_W   = 1 + OUT_EXP + OUT_FRAC
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_alt,
   input logic [IN_W-1:0]  in_word,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_word
);

   localparam int IN_BIAS  = (1 << (IN_EXP - 1)) - 1;
   localparam int OUT_BIAS = (1 << (OUT_EXP - 1)) - 1;
   localparam int STD_HUGE = IN_BIAS + OUT_BIAS + 1;
   localparam int ALT_HUGE = IN_BIAS + OUT_BIAS + 2;
   localparam int TINY     = IN_BIAS - OUT_BIAS - OUT_FRAC - 1;

   logic [IN_EXP-1:0]  ein;
   logic [IN_FRAC-1:0] fin;
   logic               nan_in;
   logic [OUT_EXP-1:0] eout;

   assign ein    = in_word[IN_W-2 -: IN_EXP];
   assign fin    = in_word[IN_FRAC-1:0];
   assign nan_in = (ein == '1) && (fin != '0);
   assign eout   = out_word[OUT_W-2 -: OUT_EXP];

   // R1
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R1
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R1
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_word));

   // R5
   sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_word[OUT_W-1] == $past(in_word[IN_W-1])));

   // R5
   zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ein == '0) |=> (out_word[OUT_W-2:0] == '0));

   // R4
   tiny_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && int'(ein) < TINY) |=> (out_word[OUT_W-2:0] == '0));

   // R3
   std_huge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_alt && int'(ein) >= STD_HUGE && ein != '1)
      |=> (eout == '1 && out_word[OUT_FRAC-1:0] == '0));

   // R8
   alt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_alt && int'(ein) >= ALT_HUGE && !nan_in)
      |=> (out_word[OUT_W-2:0] == '1));

   // R9
   alt_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_alt && nan_in) |=> (out_word[OUT_W-2:0] == '0));

   // R7
   std_qnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_alt && nan_in)
      |=> (eout == '1 && out_word[OUT_FRAC-1] == 1'b1));

endmodule

bind f32_to_f16_cvt f16cvt_chk #(
   .IN_EXP(IN_EXP), .IN_FRAC(IN_FRAC), .OUT_EXP(OUT_EXP), .OUT_FRAC(OUT_FRAC)
) u_chk (.*);

// File: tb/sim_f32_to_f16_cvt.sv
module sim_f32_to_f16_cvt;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_alt = 1'b0;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic [15:0] out_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #10 clk = ~clk;

   f32_to_f16_cvt u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_alt(in_alt),
      .in_word(in_word), .out_valid(out_valid), .out_word(out_word)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Arithmetic model: round the exact value to the ulp of its binade.
   function automatic logic [15:0] model(input logic [31:0] w, input logic alt,
                                         output string tag);
      logic s;
      int e, ee, ue, sh;
      logic [22:0] m;
      longint unsigned sig, n, rem, half;
      s = w[31];
      e = int'(w[30:23]);
      m = w[22:0];
      if (e == 255) begin
         if (m != 0) begin
            if (alt) begin tag = "R9"; return {s, 15'h0000}; end
            tag = "R7"; return {s, 5'h1f, 1'b1, m[21:13]};
         end
         if (alt) begin tag = "R8"; return {s, 15'h7fff}; end
         tag = "R6"; return {s, 15'h7c00};
      end
      if (e == 0) begin tag = "R5"; return {s, 15'h0000}; end
      ee = e - 127;
      if (ee > 16) begin
         if (alt) begin tag = "R8"; return {s, 15'h7fff}; end
         tag = "R3"; return {s, 15'h7c00};
      end
      sig = {40'd0, 1'b1, m};
      ue  = (ee < -14) ? -24 : ee - 10;
      sh  = ue - (ee - 23);
      if (sh > 40) begin tag = "R4"; return {s, 15'h0000}; end
      n    = sig >> sh;
      rem  = sig - (n << sh);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && n[0])) n = n + 1;
      if (ue == -24) begin tag = "R4"; return {s, 15'(n)}; end
      if (n == 2048) begin n = 1024; ee = ee + 1; end
      if (ee > (alt ? 16 : 15)) begin
         if (alt) begin tag = "R8"; return {s, 15'h7fff}; end
         tag = "R3"; return {s, 15'h7c00};
      end
      tag = (ee == 16) ? "R8" : "R2";
      return {s, 5'(ee + 15), 10'(n - 1024)};
   endfunction

   task automatic apply(input logic [31:0] w, input logic a);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      in_alt   = a;
      @(posedge clk);
      #1;
   endtask

   task automatic run_check(input logic [31:0] w, input logic a, input string note);
      string tag;
      logic [15:0] exp;
      exp = model(w, a, tag);
      apply(w, a);
      chk({tag, " ", note}, out_word, exp);
   endtask

   task automatic fixed(input logic [31:0] w, input logic a, input logic [15:0] exp,
                        input string tag);
      apply(w, a);
      chk(tag, out_word, exp);
   endtask

   function automatic logic [22:0] frac_pat(input int p, input logic [31:0] r);
      case (p)
         0:  return 23'h000000;
         1:  return 23'h000001;
         2:  return 23'h001000;
         3:  return 23'h001001;
         4:  return 23'h000fff;
         5:  return 23'h002000;
         6:  return 23'h003000;
         7:  return 23'h7fffff;
         8:  return 23'h7ff000;
         9:  return 23'h7fe000;
         10: return 23'h400000;
         11: return 23'h2aaaab;
         default: return r[22:0];
      endcase
   endfunction

   initial begin
      logic [15:0] held;
      #5;
      #1;
      chk("R1 reset out_word", out_word, 16'h0000);
      chk("R1 reset out_valid", {15'd0, out_valid}, 16'h0000);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 idle out_valid", {15'd0, out_valid}, 16'h0000);

      // directed boundaries
      fixed(32'h3EAAAAAB, 1'b0, 16'h3555, "R2 one third rounds down");
      fixed(32'h3F800000, 1'b0, 16'h3C00, "R2 one");
      chk("R1 valid after strobe", {15'd0, out_valid}, 16'h0001);
      fixed(32'h3F801000, 1'b0, 16'h3C00, "R2 tie to even down");
      fixed(32'h3F803000, 1'b0, 16'h3C02, "R2 tie to even up");
      fixed(32'h3FFFF000, 1'b0, 16'h4000, "R2 carry into exponent");
      fixed(32'h477FE000, 1'b0, 16'h7BFF, "R3 max finite 65504");
      fixed(32'h477FF000, 1'b0, 16'h7C00, "R3 65520 to infinity");
      fixed(32'hC77FF000, 1'b1, 16'hFC00, "R8 -65536 alternative");
      fixed(32'h47FFE000, 1'b1, 16'h7FFF, "R8 alternative max 131008");
      fixed(32'h47FFF000, 1'b1, 16'h7FFF, "R8 alternative overflow");
      fixed(32'h38800000, 1'b0, 16'h0400, "R4 min normal");
      fixed(32'h33800000, 1'b0, 16'h0001, "R4 min subnormal");
      fixed(32'h33000000, 1'b0, 16'h0000, "R4 half of min ties to zero");
      fixed(32'h33000001, 1'b0, 16'h0001, "R4 above half rounds up");
      fixed(32'hB2FFFFFF, 1'b0, 16'h8000, "R4 below half to signed zero");
      fixed(32'h387FE000, 1'b0, 16'h0400, "R4 subnormal carry to normal");
      fixed(32'h80000000, 1'b1, 16'h8000, "R5 negative zero");
      fixed(32'h00400000, 1'b0, 16'h0000, "R5 input subnormal");
      fixed(32'hFF800000, 1'b0, 16'hFC00, "R6 negative infinity");
      fixed(32'h7FC00000, 1'b0, 16'h7E00, "R7 quiet NaN");
      fixed(32'hFF800001, 1'b0, 16'hFE00, "R7 signalling NaN quieted");
      fixed(32'h7F8FE000, 1'b0, 16'h7E7F, "R7 payload kept");
      fixed(32'hFFC00000, 1'b1, 16'h8000, "R9 NaN alternative");
      fixed(32'h7F800000, 1'b1, 16'h7FFF, "R8 infinity alternative");

      // idle cycle: result held, valid dropped
      held = out_word;
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = 32'h3F800000;
      in_alt   = 1'b0;
      @(posedge clk);
      #1;
      chk("R1 hold word when idle", out_word, held);
      chk("R1 valid low when idle", {15'd0, out_valid}, 16'h0000);

      // sweep every exponent against boundary fraction patterns, both modes
      for (int e = 0; e < 256; e++) begin
         for (int p = 0; p < 24; p++) begin
            for (int a = 0; a < 2; a++) begin
               logic [31:0] w;
               lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
               w = {lfsr[31], 8'(e), frac_pat(p, lfsr)};
               run_check(w, a[0], "sweep");
            end
         end
      end

      @(negedge clk);
      in_valid = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1: watchdog expired, actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule